// File: doc/BRIEF.md
# Flash Write-Protect and Standby Controller

This unit sits between a microcontroller core and an embedded flash array. It holds two byte-wide, memory-mapped control registers. The first is a keyed command-enable register. Its upper nibble carries a 4-bit mode code. Program and erase command sequences reach the flash only while that code equals the single open value 0011. The reset value 1100 locks the array against stray writes. Every other code is reserved and also keeps the array locked.

The second register holds one standby bit, which cuts the array's steady-state current. Software sets it while it runs from RAM. The bit drops back to 0 by itself when any of three things happens: a flash read or write, an interrupt being taken, or entry into a low-power mode. During a low-power mode the array is held in standby whatever the bit says.

The standby logic is a three-state machine. ST_ACTIVE means standby is off. ST_ARMED means the software bit is set. ST_LOWPWR means standby is forced by a low-power mode. Its transitions are:
- T_ARM: ST_ACTIVE or ST_LOWPWR to ST_ARMED, on a write of 1 with no clearing event.
- T_DISARM: ST_ARMED to ST_ACTIVE, on a write of 0, a flash access or an interrupt.
- T_SLEEP: ST_ACTIVE or ST_ARMED to ST_LOWPWR, while the low-power input is high.
- T_WAKE: ST_LOWPWR to ST_ACTIVE, when the low-power input falls and no arming write arrives.
- Holds: every other case keeps the current state.

Top module: `fprot_ctrl`

## Requirements
- R1: After reset, the command register reads 0xC0 (mode 1100) and the standby register reads 0x00. Both flash_stby_o and cmd_accept_o are 0.
- R2: A write to the command register (address 0) stores data bits 7:4 as the mode code. Reads return the code in bits 7:4 and 0 in bits 3:0; for example, writing 0x3F reads back 0x30.
- R3: cmd_accept_o equals cmd_req_i in the same cycle while the stored mode is 0011, and is 0 otherwise.
- R4: A reserved mode code (anything other than 0011 or 1100) is stored as written and read back, and cmd_accept_o stays 0 under it.
- R5: A write to the standby register (address 1) with data bit 0 set to 1 sets the standby bit from the next cycle. A write with bit 0 set to 0 clears it. Reads return the bit in bit 0 and 0 in bits 7:1. Outside a low-power mode, flash_stby_o follows the bit.
- R6: A cycle with flash_acc_i high clears the standby bit and drops flash_stby_o from the next cycle.
- R7: A cycle with irq_taken_i high clears the standby bit and drops flash_stby_o from the next cycle.
- R8: While lp_mode_i is high, flash_stby_o is 1 from the next cycle whatever the bit was, the bit reads 0, and writes of 1 to it have no effect. One cycle after lp_mode_i falls, flash_stby_o is 0.
- R9: A standby write of 1 in the same cycle as a flash access, an interrupt or a high lp_mode_i leaves the bit at 0.
- R10: Addresses other than 0 and 1 read 0x00, and writes to them change neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cpu_addr_i | input | 4 | Register address |
| cpu_wr_i | input | 1 | Write strobe, one cycle per write |
| cpu_wdata_i | input | 8 | Write data |
| cpu_rdata_o | output | 8 | Read data for cpu_addr_i (combinational) |
| flash_acc_i | input | 1 | Flash read or write access in this cycle |
| irq_taken_i | input | 1 | Interrupt being taken in this cycle |
| lp_mode_i | input | 1 | High while an idle, sleep or stop mode is active |
| cmd_req_i | input | 1 | Command-sequence request from the decoder |
| cmd_accept_o | output | 1 | Request accepted under the open mode code |
| flash_stby_o | output | 1 | Flash array standby (current cut-off) |

## Verification
The checkers assume every input is synchronous to clk_i and is held 0 during reset. They also assume cpu_wr_i carries a single full write per strobe. The bench changes every input only on the falling edge, so each one is stable around the rising edge. It leaves each clearing event high for exactly one cycle, except lp_mode_i, which it holds for several cycles to exercise the forced-standby state.

// File: rtl/fprot_pkg.sv
package fprot_pkg;
    localparam int MODE_W = 4;
    localparam logic [MODE_W-1:0] MODE_LOCK = 4'b1100;
    localparam logic [MODE_W-1:0] MODE_OPEN = 4'b0011;

    typedef enum logic [1:0] {
        ST_ACTIVE = 2'd0,
        ST_ARMED  = 2'd1,
        ST_LOWPWR = 2'd2
    } stby_state_e;
endpackage

// File: rtl/fprot_mode_reg.sv
module fprot_mode_reg
    import fprot_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [MODE_W-1:0] wr_code_i,
    input  logic              cmd_req_i,
    output logic [MODE_W-1:0] mode_o,
    output logic              cmd_accept_o
);
    logic [MODE_W-1:0] mode_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            mode_q <= MODE_LOCK;
        end else if (wr_en_i) begin
            mode_q <= wr_code_i;
        end
    end

    assign mode_o       = mode_q;
    assign cmd_accept_o = cmd_req_i && (mode_q == MODE_OPEN);
endmodule

// File: rtl/fprot_stby_fsm.sv
module fprot_stby_fsm
    import fprot_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic wr_en_i,
    input  logic wr_val_i,
    input  logic clr_evt_i,
    input  logic lp_mode_i,
    output logic stby_bit_o,
    output logic stby_out_o
);
    stby_state_e state_q, state_d;
    logic        arm_req;
    logic        disarm_req;

    assign arm_req    = wr_en_i && wr_val_i && !clr_evt_i;
    assign disarm_req = clr_evt_i || (wr_en_i && !wr_val_i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_ACTIVE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ACTIVE: begin
                if (lp_mode_i)    state_d = ST_LOWPWR;
                else if (arm_req) state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (lp_mode_i)       state_d = ST_LOWPWR;
                else if (disarm_req) state_d = ST_ACTIVE;
            end
            ST_LOWPWR: begin
                if (lp_mode_i)    state_d = ST_LOWPWR;
                else if (arm_req) state_d = ST_ARMED;
                else              state_d = ST_ACTIVE;
            end
            default: state_d = ST_ACTIVE;
        endcase
    end

    always_comb begin
        stby_bit_o = 1'b0;
        stby_out_o = 1'b0;
        unique case (state_q)
            ST_ACTIVE: begin
                stby_bit_o = 1'b0;
                stby_out_o = 1'b0;
            end
            ST_ARMED: begin
                stby_bit_o = 1'b1;
                stby_out_o = 1'b1;
            end
            ST_LOWPWR: begin
                stby_bit_o = 1'b0;
                stby_out_o = 1'b1;
            end
            default: begin
                stby_bit_o = 1'b0;
                stby_out_o = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/fprot_rdmux.sv
module fprot_rdmux
    import fprot_pkg::*;
#(
    parameter int                ADDR_W    = 4,
    parameter int                DATA_W    = 8,
    parameter logic [ADDR_W-1:0] CMD_ADDR  = '0,
    parameter logic [ADDR_W-1:0] STBY_ADDR = 1
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [MODE_W-1:0] mode_i,
    input  logic              stby_bit_i,
    output logic [DATA_W-1:0] rdata_o
);
    localparam int PAD_W = DATA_W - MODE_W;

    logic [DATA_W-1:0] cmd_word;
    logic [DATA_W-1:0] stby_word;

    generate
        if (PAD_W > 0) begin : g_pad
            assign cmd_word  = {mode_i, {PAD_W{1'b0}}};
        end else begin : g_nopad
            assign cmd_word  = mode_i[MODE_W-1 -: DATA_W];
        end
    endgenerate

    assign stby_word = {{(DATA_W-1){1'b0}}, stby_bit_i};

    always_comb begin
        if (addr_i == CMD_ADDR)       rdata_o = cmd_word;
        else if (addr_i == STBY_ADDR) rdata_o = stby_word;
        else                          rdata_o = '0;
    end
endmodule

// File: rtl/fprot_ctrl.sv
module fprot_ctrl
    import fprot_pkg::*;
#(
    parameter int                ADDR_W    = 4,
    parameter int                DATA_W    = 8,
    parameter logic [ADDR_W-1:0] CMD_ADDR  = '0,
    parameter logic [ADDR_W-1:0] STBY_ADDR = 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] cpu_addr_i,
    input  logic              cpu_wr_i,
    input  logic [DATA_W-1:0] cpu_wdata_i,
    output logic [DATA_W-1:0] cpu_rdata_o,
    input  logic              flash_acc_i,
    input  logic              irq_taken_i,
    input  logic              lp_mode_i,
    input  logic              cmd_req_i,
    output logic              cmd_accept_o,
    output logic              flash_stby_o
);
    localparam int MODE_LSB = DATA_W - MODE_W;

    logic              cmd_wr;
    logic              stby_wr;
    logic [MODE_W-1:0] mode;
    logic              stby_bit;

    assign cmd_wr  = cpu_wr_i && (cpu_addr_i == CMD_ADDR);
    assign stby_wr = cpu_wr_i && (cpu_addr_i == STBY_ADDR);

    fprot_mode_reg u_mode (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .wr_en_i      (cmd_wr),
        .wr_code_i    (cpu_wdata_i[MODE_LSB +: MODE_W]),
        .cmd_req_i    (cmd_req_i),
        .mode_o       (mode),
        .cmd_accept_o (cmd_accept_o)
    );

    fprot_stby_fsm u_stby (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .wr_en_i    (stby_wr),
        .wr_val_i   (cpu_wdata_i[0]),
        .clr_evt_i  (flash_acc_i || irq_taken_i),
        .lp_mode_i  (lp_mode_i),
        .stby_bit_o (stby_bit),
        .stby_out_o (flash_stby_o)
    );

    fprot_rdmux #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .CMD_ADDR  (CMD_ADDR),
        .STBY_ADDR (STBY_ADDR)
    ) u_rd (
        .addr_i     (cpu_addr_i),
        .mode_i     (mode),
        .stby_bit_i (stby_bit),
        .rdata_o    (cpu_rdata_o)
    );
endmodule

// File: rtl/fprot_ctrl_chk.sv
module fprot_ctrl_chk
    import fprot_pkg::*;
#(
    parameter int                ADDR_W    = 4,
    parameter int                DATA_W    = 8,
    parameter logic [ADDR_W-1:0] CMD_ADDR  = '0,
    parameter logic [ADDR_W-1:0] STBY_ADDR = 1
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [ADDR_W-1:0] cpu_addr_i,
    input logic              cpu_wr_i,
    input logic [DATA_W-1:0] cpu_wdata_i,
    input logic [DATA_W-1:0] cpu_rdata_o,
    input logic              flash_acc_i,
    input logic              irq_taken_i,
    input logic              lp_mode_i,
    input logic              cmd_req_i,
    input logic              cmd_accept_o,
    input logic              flash_stby_o,
    input logic              stby_bit
);
    localparam int MODE_LSB = DATA_W - MODE_W;

    logic [MODE_W-1:0] shadow_mode;
    logic              set_wr;
    logic              clr_wr;
    logic              unmapped;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) shadow_mode <= MODE_LOCK;
        else if (cpu_wr_i && cpu_addr_i == CMD_ADDR)
            shadow_mode <= cpu_wdata_i[MODE_LSB +: MODE_W];
    end

    assign set_wr   = cpu_wr_i && cpu_addr_i == STBY_ADDR && cpu_wdata_i[0];
    assign clr_wr   = cpu_wr_i && cpu_addr_i == STBY_ADDR && !cpu_wdata_i[0];
    assign unmapped = cpu_addr_i != CMD_ADDR && cpu_addr_i != STBY_ADDR;

    assert_accept_open_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_req_i && shadow_mode == MODE_OPEN) |-> cmd_accept_o);
    assert_accept_req_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cmd_accept_o |-> cmd_req_i);
    assert_reserved_blocks_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (shadow_mode != MODE_OPEN) |-> !cmd_accept_o);
    assert_set_bit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (set_wr && !flash_acc_i && !irq_taken_i && !lp_mode_i) |=> stby_bit);
    assert_clr_bit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_wr |=> !stby_bit);
    assert_acc_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flash_acc_i |=> !stby_bit);
    assert_irq_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_taken_i |=> !stby_bit);
    assert_lp_forces_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lp_mode_i |=> (flash_stby_o && !stby_bit));
    assert_clear_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (set_wr && (flash_acc_i || irq_taken_i || lp_mode_i)) |=> !stby_bit);
    assert_unmapped_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        unmapped |-> (cpu_rdata_o == '0));
endmodule

bind fprot_ctrl fprot_ctrl_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .CMD_ADDR  (CMD_ADDR),
    .STBY_ADDR (STBY_ADDR)
) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cpu_addr_i   (cpu_addr_i),
    .cpu_wr_i     (cpu_wr_i),
    .cpu_wdata_i  (cpu_wdata_i),
    .cpu_rdata_o  (cpu_rdata_o),
    .flash_acc_i  (flash_acc_i),
    .irq_taken_i  (irq_taken_i),
    .lp_mode_i    (lp_mode_i),
    .cmd_req_i    (cmd_req_i),
    .cmd_accept_o (cmd_accept_o),
    .flash_stby_o (flash_stby_o),
    .stby_bit     (stby_bit)
);

// File: tb/fprot_ctrl_test.sv
`timescale 1ns/1ps
module fprot_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] addr = '0;
    logic       wr = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       acc = 1'b0;
    logic       irq = 1'b0;
    logic       lp = 1'b0;
    logic       req = 1'b0;
    logic       accept;
    logic       stby;

    int n_run = 0;
    int n_fail = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    fprot_ctrl uut (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .cpu_addr_i   (addr),
        .cpu_wr_i     (wr),
        .cpu_wdata_i  (wdata),
        .cpu_rdata_o  (rdata),
        .flash_acc_i  (acc),
        .irq_taken_i  (irq),
        .lp_mode_i    (lp),
        .cmd_req_i    (req),
        .cmd_accept_o (accept),
        .flash_stby_o (stby)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            n_run  = n_run + 1;
            n_fail = n_fail + 1;
            $display("FAIL watchdog (all requirements): actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_run = n_run + 1;
        if (act !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one cycle of stimulus, applied at a falling edge, cleared at the next
    task automatic cyc(input logic w, input logic [3:0] a, input logic [7:0] d,
                       input logic i, input logic f);
        @(negedge clk);
        wr = w; addr = a; wdata = d; irq = i; acc = f;
        @(negedge clk);
        wr = 1'b0; irq = 1'b0; acc = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        addr = a;
        #0.5;
        d = rdata;
    endtask

    task automatic t_reset;
        logic [7:0] d;
        rd(4'd0, d); check("R1 cmd reg", d, 8'hC0);
        rd(4'd1, d); check("R1 stby reg", d, 8'h00);
        check("R1 stby out", {7'd0, stby}, 8'd0);
        req = 1'b1; #0.5;
        check("R1 accept locked", {7'd0, accept}, 8'd0);
        req = 1'b0;
    endtask

    task automatic t_mode_rw;
        logic [7:0] d;
        cyc(1'b1, 4'd0, 8'h3F, 1'b0, 1'b0);
        rd(4'd0, d); check("R2 mode readback", d, 8'h30);
        cyc(1'b1, 4'd0, 8'hC7, 1'b0, 1'b0);
        rd(4'd0, d); check("R2 lock readback", d, 8'hC0);
    endtask

    task automatic t_accept;
        cyc(1'b1, 4'd0, 8'h30, 1'b0, 1'b0);
        req = 1'b0; #0.5;
        check("R3 no req", {7'd0, accept}, 8'd0);
        req = 1'b1; #0.5;
        check("R3 open accepts", {7'd0, accept}, 8'd1);
        req = 1'b0;
        cyc(1'b1, 4'd0, 8'hC0, 1'b0, 1'b0);
        req = 1'b1; #0.5;
        check("R3 lock blocks", {7'd0, accept}, 8'd0);
        req = 1'b0;
    endtask

    task automatic t_reserved;
        logic [7:0] d;
        cyc(1'b1, 4'd0, 8'hA5, 1'b0, 1'b0);
        rd(4'd0, d); check("R4 reserved stored", d, 8'hA0);
        req = 1'b1; #0.5;
        check("R4 reserved blocks", {7'd0, accept}, 8'd0);
        req = 1'b0;
        cyc(1'b1, 4'd0, 8'h70, 1'b0, 1'b0);
        req = 1'b1; #0.5;
        check("R4 near-open 0111 blocks", {7'd0, accept}, 8'd0);
        req = 1'b0;
    endtask

    task automatic t_stby_set;
        logic [7:0] d;
        cyc(1'b1, 4'd1, 8'hFF, 1'b0, 1'b0);
        rd(4'd1, d); check("R5 set readback", d, 8'h01);
        check("R5 stby out high", {7'd0, stby}, 8'd1);
        cyc(1'b1, 4'd1, 8'hFE, 1'b0, 1'b0);
        rd(4'd1, d); check("R5 clear readback", d, 8'h00);
        check("R5 stby out low", {7'd0, stby}, 8'd0);
    endtask

    task automatic t_acc_clear;
        logic [7:0] d;
        cyc(1'b1, 4'd1, 8'h01, 1'b0, 1'b0);
        cyc(1'b0, 4'd1, 8'h00, 1'b0, 1'b1);
        rd(4'd1, d); check("R6 access clears bit", d, 8'h00);
        check("R6 access drops stby", {7'd0, stby}, 8'd0);
    endtask

    task automatic t_irq_clear;
        logic [7:0] d;
        cyc(1'b1, 4'd1, 8'h01, 1'b0, 1'b0);
        cyc(1'b0, 4'd1, 8'h00, 1'b1, 1'b0);
        rd(4'd1, d); check("R7 irq clears bit", d, 8'h00);
        check("R7 irq drops stby", {7'd0, stby}, 8'd0);
    endtask

    task automatic t_lowpwr;
        logic [7:0] d;
        cyc(1'b1, 4'd1, 8'h01, 1'b0, 1'b0);
        @(negedge clk); lp = 1'b1;
        @(negedge clk);
        rd(4'd1, d); check("R8 lp clears bit", d, 8'h00);
        check("R8 lp forces stby", {7'd0, stby}, 8'd1);
        cyc(1'b1, 4'd1, 8'h01, 1'b0, 1'b0);
        rd(4'd1, d); check("R8 write ignored in lp", d, 8'h00);
        check("R8 stby held in lp", {7'd0, stby}, 8'd1);
        lp = 1'b0;
        @(negedge clk);
        check("R8 wake drops stby", {7'd0, stby}, 8'd0);
        // forced even when the bit was 0 before entry
        @(negedge clk); lp = 1'b1;
        @(negedge clk);
        check("R8 forced from clear bit", {7'd0, stby}, 8'd1);
        lp = 1'b0;
        @(negedge clk);
        check("R8 second wake", {7'd0, stby}, 8'd0);
    endtask

    task automatic t_race;
        logic [7:0] d;
        cyc(1'b1, 4'd1, 8'h01, 1'b1, 1'b0);
        rd(4'd1, d); check("R9 irq beats set", d, 8'h00);
        cyc(1'b1, 4'd1, 8'h01, 1'b0, 1'b1);
        rd(4'd1, d); check("R9 access beats set", d, 8'h00);
        @(negedge clk);
        lp = 1'b1; wr = 1'b1; addr = 4'd1; wdata = 8'h01;
        @(negedge clk);
        wr = 1'b0; lp = 1'b0;
        rd(4'd1, d); check("R9 lp beats set", d, 8'h00);
        @(negedge clk);
        check("R9 stby low after lp", {7'd0, stby}, 8'd0);
    endtask

    task automatic t_unmapped;
        logic [7:0] d;
        cyc(1'b1, 4'd0, 8'h30, 1'b0, 1'b0);
        cyc(1'b1, 4'd5, 8'hFF, 1'b0, 1'b0);
        cyc(1'b1, 4'd15, 8'hC1, 1'b0, 1'b0);
        rd(4'd5, d);  check("R10 unmapped reads zero", d, 8'h00);
        rd(4'd15, d); check("R10 top addr reads zero", d, 8'h00);
        rd(4'd0, d);  check("R10 cmd untouched", d, 8'h30);
        rd(4'd1, d);  check("R10 stby untouched", d, 8'h00);
        cyc(1'b1, 4'd0, 8'hC0, 1'b0, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mode_rw();
        t_accept();
        t_reserved();
        t_stby_set();
        t_acc_clear();
        t_irq_clear();
        t_lowpwr();
        t_race();
        t_unmapped();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule